// File: doc/BRIEF.md
# Pipeline hazard stall and flush controller

This block is the decode-stage control logic of a five-stage in-order pipeline that resolves branches early, in decode. It looks at the instruction in decode, the instruction in execute and the instruction in the memory stage. From these it decides whether the front of the pipeline must hold for a cycle, and whether the slot just fetched must be squashed.

A stall is needed in three cases. The first is a load in execute whose destination a decoding instruction reads. The second is a decoding branch that reads a register the execute-stage instruction is still computing. The third is a decoding branch that reads a register a load in the memory stage is still fetching. During a stall the program counter and the fetch/decode register keep their values, and the control fields loaded into the decode/execute register are zeroed, so a no-op enters execute. Older instructions keep moving. A taken branch or a jump in decode squashes the fetched instruction, unless a stall holds decode in that same cycle.

The block is purely combinational. Register index zero is hard-wired and never creates a dependency.

Top module: `hazard_ctl`

## Requirements
- R1: When `ex_load` is 1 and the nonzero `ex_dst` equals `id_src_a` or `id_src_b`, the block stalls. A stall drives `pc_en`=0, `ifid_en`=0 and `idex_bubble`=1, whatever the branch flags are.
- R2: With no stall condition present, `pc_en`=1, `ifid_en`=1 and `idex_bubble`=0. `pc_en` and `ifid_en` are always equal, and `idex_bubble` is always their inverse.
- R3: When `id_branch` is 1, `ex_wr` is 1 and the nonzero `ex_dst` equals `id_src_a` or `id_src_b`, the block stalls.
- R4: When `id_branch` is 1, `mem_load` is 1 and the nonzero `mem_dst` equals `id_src_a` or `id_src_b`, the block stalls. A branch behind a load therefore waits two cycles: once with the load in execute (R1) and once with it in the memory stage.
- R5: A destination index of 0 never causes a stall, in any stage.
- R6: With no stall, `if_flush`=1 exactly when `id_jump` is 1, or when `id_branch` and `id_taken` are both 1.
- R7: A stall forces `if_flush`=0.
- R8: When `id_branch` is 0, only the execute-stage load check (R1) can stall. `ex_wr`, `mem_load`, `mem_dst` and `id_taken` then have no effect on any output.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| ex_load | input | 1 | Instruction in execute reads data memory |
| ex_wr | input | 1 | Instruction in execute writes a register |
| ex_dst | input | W | Destination register index of the instruction in execute |
| mem_load | input | 1 | Instruction in the memory stage is a load |
| mem_dst | input | W | Destination register index of the instruction in the memory stage |
| id_src_a | input | W | First source register index of the instruction in decode |
| id_src_b | input | W | Second source register index of the instruction in decode |
| id_branch | input | 1 | Instruction in decode is a conditional branch |
| id_jump | input | 1 | Instruction in decode is an unconditional jump |
| id_taken | input | 1 | Branch compare in decode resolved as taken |
| pc_en | output | 1 | Program counter write enable |
| ifid_en | output | 1 | Fetch/decode register write enable |
| idex_bubble | output | 1 | Zero the control fields written into decode/execute |
| if_flush | output | 1 | Zero the instruction written into fetch/decode |

## Verification
The bench builds the block with 2-bit register indices. It walks every combination of the four indices and six flags, so each comparator is seen matching, missing and matching through index zero. Sweeps with the branch flag clear separate the load-use check from the two branch-only checks. Sweeps with it set separate the execute-stage producer case from the memory-stage load case. Setting the jump and taken flags together with each stall source shows that a stall wins over a flush, and that a flush appears whenever no stall does.

// File: rtl/hazard_ctl.sv
module hazard_ctl #(
  parameter int W = 5
) (
  input  logic         ex_load,
  input  logic         ex_wr,
  input  logic [W-1:0] ex_dst,
  input  logic         mem_load,
  input  logic [W-1:0] mem_dst,
  input  logic [W-1:0] id_src_a,
  input  logic [W-1:0] id_src_b,
  input  logic         id_branch,
  input  logic         id_jump,
  input  logic         id_taken,
  output logic         pc_en,
  output logic         ifid_en,
  output logic         idex_bubble,
  output logic         if_flush
);
  localparam logic [W-1:0] RZERO = '0;

  logic ex_live, mem_live;
  logic ex_hit, mem_hit;
  logic load_use, br_after_alu, br_after_load;
  logic stall, redirect;

  assign ex_live  = (ex_dst  != RZERO);
  assign mem_live = (mem_dst != RZERO);

  assign ex_hit  = ex_live  && ((ex_dst  == id_src_a) || (ex_dst  == id_src_b));
  assign mem_hit = mem_live && ((mem_dst == id_src_a) || (mem_dst == id_src_b));

  assign load_use      = ex_load && ex_hit;
  assign br_after_alu  = id_branch && ex_wr && ex_hit;
  assign br_after_load = id_branch && mem_load && mem_hit;

  assign stall    = load_use || br_after_alu || br_after_load;
  assign redirect = id_jump || (id_branch && id_taken);

  assign pc_en       = !stall;
  assign ifid_en     = !stall;
  assign idex_bubble = stall;
  assign if_flush    = redirect && !stall;
endmodule

// File: rtl/hazard_ctl_chk.sv
module hazard_ctl_chk #(
  parameter int W = 5
) (
  input logic         ex_load,
  input logic         ex_wr,
  input logic [W-1:0] ex_dst,
  input logic         mem_load,
  input logic [W-1:0] mem_dst,
  input logic [W-1:0] id_src_a,
  input logic [W-1:0] id_src_b,
  input logic         id_branch,
  input logic         id_jump,
  input logic         id_taken,
  input logic         pc_en,
  input logic         ifid_en,
  input logic         idex_bubble,
  input logic         if_flush
);
  always_comb begin
    p_load_use_r1: assert (!(ex_load && ex_dst != '0 && (ex_dst == id_src_a || ex_dst == id_src_b)) || !pc_en);
    p_enables_r2: assert (pc_en == ifid_en && idex_bubble == !ifid_en);
    p_branch_mem_r4: assert (!(id_branch && mem_load && mem_dst != '0 && (mem_dst == id_src_b)) || idex_bubble);
    p_zero_r5: assert (!(ex_dst == '0 && mem_dst == '0) || pc_en);
    p_flush_r6: assert (!(pc_en && (id_jump || (id_branch && id_taken))) || if_flush);
    p_stall_wins_r7: assert (!(idex_bubble && if_flush));
    p_nonbranch_r8: assert (id_branch || ex_load || pc_en);
  end
endmodule

bind hazard_ctl hazard_ctl_chk #(.W(W)) u_chk (
  .ex_load(ex_load), .ex_wr(ex_wr), .ex_dst(ex_dst),
  .mem_load(mem_load), .mem_dst(mem_dst),
  .id_src_a(id_src_a), .id_src_b(id_src_b),
  .id_branch(id_branch), .id_jump(id_jump), .id_taken(id_taken),
  .pc_en(pc_en), .ifid_en(ifid_en), .idex_bubble(idex_bubble), .if_flush(if_flush)
);

// File: tb/sim_hazard_ctl.sv
module sim_hazard_ctl;
  localparam int W = 2;
  localparam int NV = 1 << (4 * W + 6);

  logic clk = 1'b0;
  always #10 clk = ~clk;

  logic         ex_load = 0, ex_wr = 0, mem_load = 0;
  logic         id_branch = 0, id_jump = 0, id_taken = 0;
  logic [W-1:0] ex_dst = '0, mem_dst = '0, id_src_a = '0, id_src_b = '0;
  logic         pc_en, ifid_en, idex_bubble, if_flush;

  int checks = 0;
  int fails = 0;
  bit done = 0;

  hazard_ctl #(.W(W)) u0 (
    .ex_load(ex_load), .ex_wr(ex_wr), .ex_dst(ex_dst),
    .mem_load(mem_load), .mem_dst(mem_dst),
    .id_src_a(id_src_a), .id_src_b(id_src_b),
    .id_branch(id_branch), .id_jump(id_jump), .id_taken(id_taken),
    .pc_en(pc_en), .ifid_en(ifid_en), .idex_bubble(idex_bubble), .if_flush(if_flush)
  );

  task automatic check(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s vec flags=%b%b%b%b%b%b ex=%0d mem=%0d a=%0d b=%0d act=%0d exp=%0d",
               req, ex_load, ex_wr, mem_load, id_branch, id_jump, id_taken,
               ex_dst, mem_dst, id_src_a, id_src_b, act, exp);
    end
  endtask

  initial begin
    @(negedge clk);
    #1;
    check("R2 idle", int'(pc_en), 1);
    check("R2 idle", int'(ifid_en), 1);
    check("R2 idle", int'(idex_bubble), 0);
    check("R6 idle", int'(if_flush), 0);

    for (int v = 0; v < NV; v++) begin
      int f, xa, xb, xe, xm;
      bit e_src, m_src, need, rd;
      string why;
      @(negedge clk);
      f  = v & 63;
      xe = (v >> 6) & 3;
      xm = (v >> 8) & 3;
      xa = (v >> 10) & 3;
      xb = (v >> 12) & 3;
      ex_load   = f[0];
      ex_wr     = f[1];
      mem_load  = f[2];
      id_branch = f[3];
      id_jump   = f[4];
      id_taken  = f[5];
      ex_dst    = W'(xe);
      mem_dst   = W'(xm);
      id_src_a  = W'(xa);
      id_src_b  = W'(xb);
      #1;
      // R5: index zero is never a producer
      e_src = (xe > 0) && (xe == xa || xe == xb);
      m_src = (xm > 0) && (xm == xa || xm == xb);
      need = 0;
      why = "R2";
      if (f[0] && e_src) begin need = 1; why = "R1"; end
      else if (f[3] && f[1] && e_src) begin need = 1; why = "R3"; end
      else if (f[3] && f[2] && m_src) begin need = 1; why = "R4"; end
      else if (!f[3]) why = "R8";
      else if ((xe == 0 || xm == 0) && (f[1] || f[2])) why = "R5";
      rd = f[4] || (f[3] && f[5]);
      check(why, int'(pc_en), need ? 0 : 1);
      check(why, int'(ifid_en), need ? 0 : 1);
      check(why, int'(idex_bubble), need ? 1 : 0);
      check(need ? "R7" : "R6", int'(if_flush), (rd && !need) ? 1 : 0);
    end
    done = 1;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    repeat (NV + 1000) @(posedge clk);
    if (!done) begin
      fails++;
      $display("FAIL watchdog act=timeout exp=completion");
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end
endmodule